// File: doc/BRIEF.md
# Memory Sleep Entry and Exit Sequencer

This controller puts a synchronous memory into a low-power retention state and brings it back out. A sleep request arrives with no timing relation to the clock. It is conditioned by a chain of flip-flops and then drives a small state machine. That machine spends a fixed number of cycles on entry and a fixed number on exit. After exit it holds a recovery window before normal accesses may resume. The array contents are not touched, so stored data survives the sleep period.

For the whole sequence, from the first cycle of entry until recovery ends, the block asserts a blocking signal to the command decoder. On the first cycle of entry it pulses a drop signal so the decoder discards any access still in flight. Those accesses are treated as invalid and need not complete. A sticky error flag records two kinds of misuse: a sleep request that arrives while the device is still selected, and chip-enable activity during the exit and recovery window. Only reset clears the flag.

Top module: `sleep_seq_ctrl`

## Requirements
- R1: After reset, `sleep_on_o`, `cmd_block_o`, `pend_drop_o` and `seq_err_o` are all 0.
- R2: `sleep_req_i` passes through a two-flop synchronizer. Suppose it is raised between clock edges and held. `cmd_block_o` stays 0 through the second rising edge after that and becomes 1 after the third.
- R3: `sleep_on_o` becomes 1 exactly two cycles after `cmd_block_o` rises. This is the entry latency. `cmd_block_o` is 1 whenever `sleep_on_o` is 1.
- R4: `pend_drop_o` is a one-cycle pulse in the first cycle that `cmd_block_o` is 1.
- R5: Suppose `sleep_req_i` is lowered between edges while the block is asleep. `sleep_on_o` stays 1 through the fourth rising edge after that and becomes 0 after the fifth. This covers synchronization, one state step and two exit cycles.
- R6: After `sleep_on_o` falls, `cmd_block_o` stays 1 for a further two-cycle recovery window and becomes 0 after the second of those edges.
- R7: `seq_err_o` becomes 1 on the edge that starts entry if `dev_idle_i` is 0 at that edge.
- R8: `seq_err_o` becomes 1 if `chip_en_i` is 1 at any edge during the exit cycles or the recovery window.
- R9: `chip_en_i` has no effect on `seq_err_o` while awake or fully asleep. `dev_idle_i` has no effect except on the edge that starts entry.
- R10: Once `seq_err_o` is 1, it stays 1 until reset.
- R11: Once entry has begun, it always runs to completion, even if the request is withdrawn. `sleep_on_o` then rises and the normal exit and recovery follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req_i | input | 1 | Asynchronous sleep request, active high |
| dev_idle_i | input | 1 | 1 when the device is deselected |
| chip_en_i | input | 1 | 1 when any chip enable is active |
| sleep_on_o | output | 1 | Sleep state active (asleep or exiting) |
| cmd_block_o | output | 1 | Blocks new accesses in the command decoder |
| pend_drop_o | output | 1 | One-cycle pulse: discard pending access |
| seq_err_o | output | 1 | Sticky misuse flag |

## Verification
The assertions rely on `sleep_req_i` being free of metastability once it has passed the two synchronizer flops. The stimulus never changes the request near a rising edge; it drives every input on the falling edge. The assertions also assume the state machine reads only the synchronized request. No bench scenario changes the request within a clock cycle. Scenarios that need chip-enable activity keep it out of the exit window, except for the one case that deliberately puts it there.

// File: rtl/sleep_seq_pkg.sv
// Shared types for the sleep sequencer.
// Assumes: single clock domain after the request synchronizer.
package sleep_seq_pkg;

    typedef enum logic [2:0] {
        SQ_AWAKE   = 3'd0,
        SQ_ENTER   = 3'd1,
        SQ_ASLEEP  = 3'd2,
        SQ_EXIT    = 3'd3,
        SQ_RECOVER = 3'd4
    } sq_state_e;

endpackage

// File: rtl/sleep_req_sync.sv
// Multi-flop synchronizer for the asynchronous sleep request.
// Assumes: STAGES >= 2; the output is safe to use in the clk domain.
module sleep_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the request through the flop chain, clearing on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/sleep_phase_timer.sv
// Cycle counter for one phase of the sequence; restarts on each phase change.
// Assumes: limit >= 1; done is high in the last cycle of the phase.
module sleep_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_q;

    // Count cycles in the current phase, saturating at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = (cnt_q == (limit_i - 1'b1));

endmodule

// File: rtl/sleep_err_guard.sv
// Sticky misuse detector: entry while selected, or chip enable in the exit window.
// Assumes: entry_start_i is high only on the edge that starts entry.
module sleep_err_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic entry_start_i,
    input  logic dev_idle_i,
    input  logic window_i,
    input  logic chip_en_i,
    output logic err_o
);

    logic err_q;

    // Latch any violation until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if ((entry_start_i && !dev_idle_i) || (window_i && chip_en_i)) begin
            err_q <= 1'b1;
        end
    end

    assign err_o = err_q;

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

endmodule

// File: rtl/sleep_seq_ctrl.sv
// Sleep entry/exit sequencer top: synchronizes the request, times entry,
// exit and recovery, blocks accesses and flags misuse.
// Assumes: all cycle counts >= 1; SYNC_STAGES >= 2.
module sleep_seq_ctrl
    import sleep_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_CYC   = 2,
    parameter int EXIT_CYC    = 2,
    parameter int RECOV_CYC   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req_i,
    input  logic dev_idle_i,
    input  logic chip_en_i,
    output logic sleep_on_o,
    output logic cmd_block_o,
    output logic pend_drop_o,
    output logic seq_err_o
);

    localparam int MAX_A = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
    localparam int MAX_C = (MAX_A > RECOV_CYC) ? MAX_A : RECOV_CYC;
    localparam int CNT_W = $clog2(MAX_C + 1);

    sq_state_e        state_q, state_d;
    logic             req_s;
    logic             tmr_done;
    logic             tmr_restart;
    logic [CNT_W-1:0] tmr_limit;
    logic             entry_start;
    logic             in_window;
    logic             first_enter_q;

    sleep_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sleep_req_i),
        .sync_o  (req_s)
    );

    // Pick the next phase from the synchronized request and the timer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_AWAKE:   if (req_s)    state_d = SQ_ENTER;
            SQ_ENTER:   if (tmr_done) state_d = SQ_ASLEEP;
            SQ_ASLEEP:  if (!req_s)   state_d = SQ_EXIT;
            SQ_EXIT:    if (tmr_done) state_d = SQ_RECOVER;
            SQ_RECOVER: if (tmr_done) state_d = SQ_AWAKE;
            default:                  state_d = SQ_AWAKE;
        endcase
    end

    // Hold the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_AWAKE;
        end else begin
            state_q <= state_d;
        end
    end

    // Mark the first cycle of entry for the drop pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_enter_q <= 1'b0;
        end else begin
            first_enter_q <= entry_start;
        end
    end

    // Select the length of the running phase.
    always_comb begin
        unique case (state_q)
            SQ_ENTER:   tmr_limit = CNT_W'(ENTRY_CYC);
            SQ_EXIT:    tmr_limit = CNT_W'(EXIT_CYC);
            SQ_RECOVER: tmr_limit = CNT_W'(RECOV_CYC);
            default:    tmr_limit = CNT_W'(1);
        endcase
    end

    assign tmr_restart = (state_d != state_q);

    sleep_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (tmr_restart),
        .limit_i   (tmr_limit),
        .done_o    (tmr_done)
    );

    assign entry_start = (state_q == SQ_AWAKE) && req_s;
    assign in_window   = (state_q == SQ_EXIT) || (state_q == SQ_RECOVER);

    sleep_err_guard u_guard (
        .clk           (clk),
        .rst_n         (rst_n),
        .entry_start_i (entry_start),
        .dev_idle_i    (dev_idle_i),
        .window_i      (in_window),
        .chip_en_i     (chip_en_i),
        .err_o         (seq_err_o)
    );

    assign sleep_on_o  = (state_q == SQ_ASLEEP) || (state_q == SQ_EXIT);
    assign cmd_block_o = (state_q != SQ_AWAKE);
    assign pend_drop_o = first_enter_q;

    assert_sleep_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_on_o |-> cmd_block_o);

    assert_awake_no_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_AWAKE) |=> (state_q == SQ_AWAKE || state_q == SQ_ENTER));

    assert_entry_runs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_ENTER && !tmr_done) |=> (state_q == SQ_ENTER));

    assert_exit_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_EXIT && !tmr_done) |=> (state_q == SQ_EXIT));

    assert_drop_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_drop_o |=> !pend_drop_o);

    assert_release_after_recov_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_block_o) |-> ($past(state_q) == SQ_RECOVER));

endmodule

// File: tb/sleep_seq_ctrl_bench.sv
module sleep_seq_ctrl_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0;
    logic dev_idle = 1'b1;
    logic chip_en = 1'b0;
    logic sleep_on, cmd_block, pend_drop, seq_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sleep_seq_ctrl u_sleep_seq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req_i (sleep_req),
        .dev_idle_i  (dev_idle),
        .chip_en_i   (chip_en),
        .sleep_on_o  (sleep_on),
        .cmd_block_o (cmd_block),
        .pend_drop_o (pend_drop),
        .seq_err_o   (seq_err)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        sleep_req = 1'b0; dev_idle = 1'b1; chip_en = 1'b0;
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "sleep_on", sleep_on, 1'b0);
        chk("R1", "cmd_block", cmd_block, 1'b0);
        chk("R1", "pend_drop", pend_drop, 1'b0);
        chk("R1", "seq_err", seq_err, 1'b0);
    endtask

    // Full legal entry and exit with timing checks.
    task automatic t_full_cycle();
        do_reset();
        sleep_req = 1'b1;
        tick(2);
        chk("R2", "block after 2 edges", cmd_block, 1'b0);
        tick(1);
        chk("R2", "block after 3 edges", cmd_block, 1'b1);
        chk("R4", "drop first cycle", pend_drop, 1'b1);
        chk("R3", "sleep not yet", sleep_on, 1'b0);
        tick(1);
        chk("R4", "drop gone", pend_drop, 1'b0);
        chk("R3", "sleep one cycle in", sleep_on, 1'b0);
        tick(1);
        chk("R3", "sleep on", sleep_on, 1'b1);
        tick(3);
        chk("R3", "sleep held", sleep_on, 1'b1);
        sleep_req = 1'b0;
        tick(4);
        chk("R5", "sleep after 4 edges", sleep_on, 1'b1);
        tick(1);
        chk("R5", "sleep after 5 edges", sleep_on, 1'b0);
        chk("R6", "block in recovery", cmd_block, 1'b1);
        tick(1);
        chk("R6", "block recovery 2nd", cmd_block, 1'b1);
        tick(1);
        chk("R6", "block released", cmd_block, 1'b0);
        chk("R8", "no error legal", seq_err, 1'b0);
    endtask

    // Request while still selected.
    task automatic t_selected_entry();
        do_reset();
        dev_idle = 1'b0;
        sleep_req = 1'b1;
        tick(2);
        chk("R7", "err before entry", seq_err, 1'b0);
        tick(1);
        chk("R7", "err at entry", seq_err, 1'b1);
        dev_idle = 1'b1;
        tick(5);
        chk("R10", "err sticky", seq_err, 1'b1);
    endtask

    // Chip enable during the exit window, then sticky after it drops.
    task automatic t_recovery_violation();
        do_reset();
        sleep_req = 1'b1;
        tick(6);
        sleep_req = 1'b0;
        tick(3);
        chk("R8", "no err before window use", seq_err, 1'b0);
        chip_en = 1'b1;
        tick(1);
        chip_en = 1'b0;
        chk("R8", "err on chip enable", seq_err, 1'b1);
        tick(6);
        chk("R10", "err held after", seq_err, 1'b1);
    endtask

    // Chip enable and selection changes outside the window are ignored.
    task automatic t_ignored_inputs();
        do_reset();
        chip_en = 1'b1;
        dev_idle = 1'b0;
        tick(4);
        chk("R9", "awake chip enable", seq_err, 1'b0);
        chip_en = 1'b0;
        dev_idle = 1'b1;
        sleep_req = 1'b1;
        tick(6);
        chip_en = 1'b1;
        dev_idle = 1'b0;
        tick(3);
        chk("R9", "asleep chip enable", seq_err, 1'b0);
        chk("R9", "still asleep", sleep_on, 1'b1);
        chip_en = 1'b0;
        dev_idle = 1'b1;
        sleep_req = 1'b0;
        tick(8);
        chk("R9", "after exit", seq_err, 1'b0);
    endtask

    // Request withdrawn during entry.
    task automatic t_withdrawn();
        do_reset();
        sleep_req = 1'b1;
        tick(3);
        chk("R11", "entry begun", cmd_block, 1'b1);
        sleep_req = 1'b0;
        tick(2);
        chk("R11", "entry completes", sleep_on, 1'b1);
        tick(3);
        chk("R11", "exit done", sleep_on, 1'b0);
        tick(1);
        chk("R11", "recovery", cmd_block, 1'b1);
        tick(1);
        chk("R11", "released", cmd_block, 1'b0);
    endtask

    initial begin
        t_reset();
        t_full_cycle();
        t_selected_entry();
        t_recovery_violation();
        t_ignored_inputs();
        t_withdrawn();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule